// File: doc/BRIEF.md
# Three-Wire Half-Duplex Register Master

This block is the host-side master for a serial register port on a display panel. The link uses three wires: an active-low select, a clock, and one data line that carries traffic in both directions. The host hands over one command at a time: an address, write data and a read flag. The block turns each command into a fixed 16-clock frame on the link. For a write frame the block drives the data line for all 16 bits. For a read frame it drives only the 8-bit address, then lets go of the line and shifts in the panel's 8-bit reply.

Command intake uses a valid/ready handshake. `cmd_ready` is high only while the block is idle. Back-pressure lasts from acceptance to the end of the guard interval. A held command waits and is never dropped. The fields are captured on the accepting edge, so changes to them after that edge have no effect. Read results come back as a one-cycle `rsp_valid` strobe with `rsp_data`. This output has no back-pressure, so the host must take the byte in the strobe cycle.

The link timing is set by three parameters, each counted in system clocks: the clock-low (setup) time `SETUP_CYC`, the clock-high time `HIGH_CYC` and the deselect guard time `GUARD_CYC`. Before the reply reaches the shift register, it passes through a two-flop synchroniser. For that reason `SETUP_CYC + HIGH_CYC` must be at least 3.

Top module: `tw_reg_master`

## Requirements
- R1: A write frame holds 16 bits, sent MSB first. The address is the upper byte and the write data is the lower byte. Each bit is on `link_sdo` before the rising `link_sck` edge that carries it.
- R2: A read frame sends the address byte first, with bit 7 forced to 1. It then takes 8 reply bits, MSB first, one per rising clock. After the 16th clock, `rsp_data` holds the reply and `rsp_valid` pulses for exactly one cycle. Writes never raise `rsp_valid`.
- R3: `link_sdo_oe` is low from the falling clock after the 8th rising edge of a read frame until select rises. At all other times it is high, including for all of a write frame and while deselected.
- R4: `link_cs_n` is active low. It falls while `link_sck` and `link_sdo` are both low. `link_sck` stays low while deselected. `link_cs_n` rises only with `link_sck` low, after exactly 16 rising edges.
- R5: `link_sdo` changes only while `link_sck` is low. It holds steady throughout each clock-high phase.
- R6: Between two frames, `link_cs_n` stays high for at least `GUARD_CYC + 1` system clocks.
- R7: `cmd_ready` is high only while deselected and idle. A command held during back-pressure is accepted later, without loss and in order. Field changes after the accepting edge do not affect the frame.
- R8: After reset, `link_cs_n` is 1, `link_sck` is 0, `link_sdo_oe` is 1, `cmd_ready` is 1 and `rsp_valid` is 0.
- R9: Every clock-high phase lasts exactly `HIGH_CYC` clocks. Every clock-low phase between two rising edges of the same frame lasts exactly `SETUP_CYC` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle strobe: read result ready |
| rsp_data | output | DATA_W | Read result |
| link_cs_n | output | 1 | Link select, active low |
| link_sck | output | 1 | Link clock |
| link_sdo | output | 1 | Data line value when driven |
| link_sdo_oe | output | 1 | Data line drive enable |
| link_sdi | input | 1 | Data line level as seen at the pin |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the panel changes the shared data line only after a falling clock edge and holds it through the following high phase. The bench's panel model drives each reply bit on the falling clock edge, keeps it until the next fall, and parks the line high when it is not replying. The command driver offers write addresses below 0x80 only, so the model always decodes the frame direction from bit 7 of the address byte.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GUARD
  } tw_state_e;
endpackage

// File: rtl/tw_sync2.sv
module tw_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(expired)) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tw_frame_shifter.sv
module tw_frame_shifter #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned RX_BITS    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_frame,
  input  logic                  tx_shift,
  input  logic                  rx_shift,
  input  logic                  rx_bit,
  output logic                  tx_bit,
  output logic [RX_BITS-1:0]    rx_byte
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [RX_BITS-1:0]    rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_q <= '0;
    else if (load)
      tx_q <= load_frame;
    else if (tx_shift)
      tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rx_q <= '0;
    else if (rx_shift)
      rx_q <= {rx_q[RX_BITS-2:0], rx_bit};
  end

  assign tx_bit  = tx_q[FRAME_BITS-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master #(
  parameter int unsigned SETUP_CYC = 3,
  parameter int unsigned HIGH_CYC  = 3,
  parameter int unsigned GUARD_CYC = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rd,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              link_cs_n,
  output logic              link_sck,
  output logic              link_sdo,
  output logic              link_sdo_oe,
  input  logic              link_sdi
);
  import tw_pkg::*;

  localparam int unsigned FRAME_BITS = ADDR_W + DATA_W;
  localparam int unsigned MAX_A      = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int unsigned MAX_CYC    = (MAX_A > GUARD_CYC) ? MAX_A : GUARD_CYC;
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
  localparam int unsigned BIT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] GUARD_LD = CNT_W'(GUARD_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] RX_FIRST = BIT_W'(ADDR_W);

  tw_state_e state_q, state_d;
  logic [BIT_W-1:0] bit_q;
  logic             rd_q;
  logic             accept;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_exp;
  logic             bit_done;
  logic             last_bit;
  logic             in_reply;
  logic             sdi_sync;
  logic             tx_bit;
  logic [DATA_W-1:0] rx_byte;
  logic [FRAME_BITS-1:0] frame_d;
  logic             rsp_q;

  assign accept   = cmd_valid && cmd_ready;
  assign bit_done = (state_q == ST_HIGH) && t_exp;
  assign last_bit = (bit_q == LAST_BIT);
  assign frame_d  = cmd_rd ? {cmd_addr | {1'b1, {(ADDR_W-1){1'b0}}}, {DATA_W{1'b0}}}
                           : {cmd_addr, cmd_wdata};

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_START; t_load = 1'b1; t_val = SETUP_LD;
      end
      ST_START: if (t_exp) begin
        state_d = ST_LOW; t_load = 1'b1; t_val = SETUP_LD;
      end
      ST_LOW: if (t_exp) begin
        state_d = ST_HIGH; t_load = 1'b1; t_val = HIGH_LD;
      end
      ST_HIGH: if (t_exp) begin
        state_d = last_bit ? ST_TAIL : ST_LOW; t_load = 1'b1; t_val = SETUP_LD;
      end
      ST_TAIL: if (t_exp) begin
        state_d = ST_GUARD; t_load = 1'b1; t_val = GUARD_LD;
      end
      ST_GUARD: if (t_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rsp_q   <= bit_done && last_bit && rd_q;
      if (accept) begin
        bit_q <= '0;
        rd_q  <= cmd_rd;
      end else if (bit_done) begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  tw_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  tw_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(link_sdi), .q(sdi_sync)
  );

  tw_frame_shifter #(.FRAME_BITS(FRAME_BITS), .RX_BITS(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_frame(frame_d),
    .tx_shift(bit_done), .rx_shift(bit_done && rd_q && (bit_q >= RX_FIRST)),
    .rx_bit(sdi_sync), .tx_bit(tx_bit), .rx_byte(rx_byte)
  );

  assign in_reply    = rd_q && (bit_q >= RX_FIRST) &&
                       (state_q == ST_LOW || state_q == ST_HIGH || state_q == ST_TAIL);
  assign cmd_ready   = (state_q == ST_IDLE);
  assign link_cs_n   = (state_q == ST_IDLE) || (state_q == ST_GUARD);
  assign link_sck    = (state_q == ST_HIGH);
  assign link_sdo_oe = !in_reply;
  assign link_sdo    = (!in_reply && (state_q == ST_LOW || state_q == ST_HIGH)) ? tx_bit : 1'b0;
  assign rsp_valid   = rsp_q;
  assign rsp_data    = rx_byte;

  // R3
  idle_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_cs_n |-> link_sdo_oe);
  // R3
  rsp_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!link_sdo_oe && !link_cs_n));
  // R4
  sck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_cs_n |-> !link_sck);
  // R4
  cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_cs_n) |-> (!link_sck && !$past(link_sck)));
  // R5
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_sck && $past(link_sck)) |-> $stable(link_sdo));
  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> link_cs_n);
  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: tb/tb_tw_reg_master.sv
module tb_tw_reg_master;
  localparam int CLK_PERIOD = 10;
  localparam int SETUP = 3;
  localparam int HIGHC = 3;
  localparam int GUARD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_rd = 1'b0;
  logic [7:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, link_cs_n, link_sck, link_sdo, link_sdo_oe;
  logic [7:0] rsp_data;
  logic link_sdi = 1'b1;

  int checks = 0;
  int fails = 0;
  bit started = 0;

  logic [16:0] exp_q[$];
  logic [7:0]  rsp_q[$];
  logic [7:0]  shadow [0:127];
  logic [7:0]  pmem   [0:127];

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_reg_master #(.SETUP_CYC(SETUP), .HIGH_CYC(HIGHC), .GUARD_CYC(GUARD)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rd(cmd_rd), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .link_cs_n(link_cs_n),
    .link_sck(link_sck), .link_sdo(link_sdo), .link_sdo_oe(link_sdo_oe),
    .link_sdi(link_sdi)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // panel model
  int pcnt = 0;
  logic [7:0] p_hi = '0, p_lo = '0;
  bit p_rd = 0;

  always @(negedge link_cs_n) if (started) begin
    pcnt = 0; p_hi = '0; p_lo = '0; p_rd = 0;
    check(link_sdo == 1'b0 && link_sck == 1'b0 && link_sdo_oe, "R4 select entry", link_sdo, 0);
  end

  always @(posedge link_sck) if (started) begin
    if (pcnt < 8) begin
      check(link_sdo_oe == 1'b1, "R3 address driven", link_sdo_oe, 1);
      p_hi = {p_hi[6:0], link_sdo};
    end else if (!p_rd) begin
      check(link_sdo_oe == 1'b1, "R3 write data driven", link_sdo_oe, 1);
      p_lo = {p_lo[6:0], link_sdo};
    end else begin
      check(link_sdo_oe == 1'b0, "R3 released while sampling", link_sdo_oe, 0);
    end
    pcnt++;
    if (pcnt == 8) p_rd = p_hi[7];
  end

  always @(negedge link_sck) if (started) begin
    if (!link_cs_n && p_rd && pcnt >= 8 && pcnt < 16)
      link_sdi = pmem[p_hi[6:0]][15 - pcnt];
    else
      link_sdi = 1'b1;
  end

  always @(posedge link_cs_n) if (started) begin
    logic [16:0] e;
    link_sdi = 1'b1;
    check(pcnt == 16, "R4 sixteen clocks", pcnt, 16);
    if (exp_q.size() == 0) begin
      check(0, "R7 unexpected frame", {p_hi, p_lo}, 0);
    end else begin
      e = exp_q.pop_front();
      if (e[16]) check(p_hi == e[15:8], "R2 read address byte", p_hi, e[15:8]);
      else check({p_hi, p_lo} == e[15:0], "R1 write frame", {p_hi, p_lo}, e[15:0]);
    end
    if (!p_rd) pmem[p_hi[6:0]] = p_lo;
  end

  // response monitor
  always @(negedge clk) if (started && rsp_valid) begin
    if (rsp_q.size() == 0) check(0, "R2 strobe without read", rsp_data, 0);
    else begin
      logic [7:0] r;
      r = rsp_q.pop_front();
      check(rsp_data == r, "R2 read data", rsp_data, r);
    end
  end

  // pin timing monitor
  int hi_run = 0, lo_run = 0, rises = 0, cs_hi_run = 0;
  bit prev_sck = 0, prev_cs = 1, prev_sdo = 0, seen_txn = 0;
  always @(negedge clk) if (started) begin
    if (link_sck && link_cs_n) check(0, "R4 clock while deselected", 1, 0);
    if (!link_cs_n && cmd_ready) check(0, "R7 ready while busy", 1, 0);
    if (link_sck && prev_sck && link_sdo != prev_sdo) check(0, "R5 data moved in high phase", link_sdo, prev_sdo);
    if (link_sck) hi_run++;
    if (!link_sck && prev_sck) begin
      check(hi_run == HIGHC, "R9 high phase", hi_run, HIGHC);
      hi_run = 0;
    end
    if (!link_cs_n && !link_sck) lo_run++;
    if (link_sck && !prev_sck) begin
      if (rises > 0) check(lo_run == SETUP, "R9 low phase", lo_run, SETUP);
      lo_run = 0;
      rises++;
    end
    if (link_cs_n) cs_hi_run++;
    if (!link_cs_n && prev_cs) begin
      if (seen_txn) check(cs_hi_run >= GUARD + 1, "R6 guard", cs_hi_run, GUARD + 1);
      seen_txn = 1; cs_hi_run = 0; rises = 0; lo_run = 0;
    end
    prev_sck = link_sck; prev_cs = link_cs_n; prev_sdo = link_sdo;
  end

  task automatic send(input bit rd, input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({rd, rd ? (a | 8'h80) : a, rd ? 8'h00 : d});
    if (rd) rsp_q.push_back(shadow[a[6:0]]);
    else shadow[a[6:0]] = d;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_addr = a; cmd_wdata = d;
    forever begin
      if (cmd_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    // R7: scramble fields after acceptance
    cmd_valid = 1'b0; cmd_rd = ~rd; cmd_addr = ~a; cmd_wdata = ~d;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      pmem[i] = 8'((i * 37 + 5) & 8'hff);
      shadow[i] = 8'((i * 37 + 5) & 8'hff);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    check(link_cs_n == 1'b1, "R8 select idle", link_cs_n, 1);
    check(link_sck == 1'b0, "R8 clock idle", link_sck, 0);
    check(link_sdo_oe == 1'b1, "R8 drive idle", link_sdo_oe, 1);
    check(cmd_ready == 1'b1, "R8 ready", cmd_ready, 1);
    check(rsp_valid == 1'b0, "R8 no strobe", rsp_valid, 0);
    started = 1;

    send(0, 8'h00, 8'h00);
    send(0, 8'h7f, 8'hff);
    send(0, 8'h55, 8'ha5);
    send(1, 8'h55, 8'h00);
    send(1, 8'h00, 8'h00);
    send(1, 8'h7f, 8'h00);
    send(1, 8'h2a, 8'h00);
    send(0, 8'h2a, 8'h81);
    send(1, 8'h2a, 8'h00);
    send(1, 8'h01, 8'h00);
    send(0, 8'h40, 8'h3c);
    send(1, 8'h40, 8'h00);

    while (exp_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(link_cs_n == 1'b1 && cmd_ready == 1'b1, "R7 back to idle", cmd_ready, 1);
    finish_run();
  end
endmodule